// File: doc/BRIEF.md
# CAN Controller Status Word and Error Counters

This block holds the 32-bit global status word of a CAN controller together with the receive and transmit error counters. Single-cycle event strobes from the protocol engine drive it. These strobes report received messages, overruns, transmission requests and completions, and counter increments and decrements. It also takes the pending flags of the transmit buffers, the activity flags, a reset-mode flag and a programmable warning limit. A register-bus write port reaches the counter bytes only.

The status word is read-only except for the two counter bytes. Those bytes can be loaded only while the controller sits in reset mode. The warning flag and the bus-off flag are not stored. They are derived from the counters: one against the programmable limit, the other against the fixed value 255.

Top module: `can_stat_reg`

## Requirements
- R1: After synchronous reset the status word reads 0x0000_000C (bits 2 and 3 set, counters zero, every other bit zero).
- R2: Bit 0 (message available) is set by a store strobe. A release strobe clears it only when the "more waiting" input is low. A store in the same cycle as a release leaves it set.
- R3: Bit 1 (overrun) is set by an overrun strobe and stays set until a clear-overrun strobe. A set in the same cycle as a clear wins.
- R4: Bit 2 is 1 in the same cycle exactly when no transmit buffer pending flag is high.
- R5: Bit 3 (all transmissions done) is cleared by a transmit-request strobe and set by an all-done strobe. A request in the same cycle as an all-done wins.
- R6: Bits 4 and 5 follow the receive-active and transmit-active inputs in the same cycle.
- R7: Each counter steps by one per increment or decrement strobe. Both strobes together leave it unchanged. It saturates at 0 and at 255.
- R8: Bit 6 is 1 when either counter is greater than or equal to the warning limit.
- R9: Bit 7 (bus-off) is 1 exactly while the transmit counter equals 255.
- R10: In reset mode, a write with byte enable 2 loads bits 23:16 into the receive counter, and a write with byte enable 3 loads bits 31:24 into the transmit counter. Each takes effect on the next cycle and wins over a strobe in the same cycle.
- R11: A write outside reset mode changes nothing in the status word.
- R12: Bits 15:8 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_store_i | input | 1 | Strobe: a received message was placed in the buffer |
| rx_release_i | input | 1 | Strobe: software released the receive buffer |
| rx_more_i | input | 1 | Another received message is waiting |
| ovr_evt_i | input | 1 | Strobe: a message was lost to overrun |
| ovr_clr_i | input | 1 | Strobe: clear-overrun command |
| tx_pend_i | input | NUM_TXBUF | Pending flag of each transmit buffer |
| tx_req_i | input | 1 | Strobe: a new transmission was requested |
| tx_all_ok_i | input | 1 | Strobe: all requested transmissions completed |
| rx_active_i | input | 1 | A reception is in progress |
| tx_active_i | input | 1 | A transmission is in progress |
| rxerr_inc_i | input | 1 | Receive counter increment strobe |
| rxerr_dec_i | input | 1 | Receive counter decrement strobe |
| txerr_inc_i | input | 1 | Transmit counter increment strobe |
| txerr_dec_i | input | 1 | Transmit counter decrement strobe |
| reset_mode_i | input | 1 | Controller is in reset mode |
| warn_lim_i | input | 8 | Error warning limit |
| wr_en_i | input | 1 | Register write strobe |
| wr_be_i | input | 4 | Byte enables of the write |
| wr_data_i | input | 32 | Write data |
| status_o | output | 32 | Status word |

## Verification
The bench drives both counters into their saturation points. A design that wraps would show 0 after 255 or 255 after 0, and bus-off would drop. It collides software writes with strobes, where a design with the wrong priority would leave the counter one step off the written value. It writes outside reset mode, which a leaky design would let through to a counter. It also collides set and clear strobes on the sticky flags and places the warning limit exactly at a counter value, so a strict comparison would miss the equal case.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;

    localparam int CNT_W   = 8;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam int NUM_CNT = 2;   // index 0: receive, 1: transmit
    localparam int IDX_RX  = 0;
    localparam int IDX_TX  = 1;

    typedef struct packed {
        logic [CNT_W-1:0] txerr;
        logic [CNT_W-1:0] rxerr;
        logic [7:0]       zero;
        logic             busoff;
        logic             warn;
        logic             tx_busy;
        logic             rx_busy;
        logic             tx_done;
        logic             tx_free;
        logic             overrun;
        logic             rx_avail;
    } status_t;

    function automatic logic [CNT_W-1:0] sat_step(
        input logic [CNT_W-1:0] cur,
        input logic             up,
        input logic             down
    );
        logic [CNT_W-1:0] nxt;
        nxt = cur;
        if (up && !down && cur != CNT_MAX)
            nxt = cur + 1'b1;
        else if (down && !up && cur != '0)
            nxt = cur - 1'b1;
        return nxt;
    endfunction

endpackage

// File: rtl/can_stat_errcnt.sv
module can_stat_errcnt
    import can_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else
            cnt <= sat_step(cnt, inc, dec);
    end
endmodule

// File: rtl/can_stat_flags.sv
module can_stat_flags (
    input  logic clk,
    input  logic rst,
    input  logic rx_store,
    input  logic rx_release,
    input  logic rx_more,
    input  logic ovr_evt,
    input  logic ovr_clr,
    input  logic tx_req,
    input  logic tx_all_ok,
    output logic rx_avail,
    output logic overrun,
    output logic tx_done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_avail <= 1'b0;
            overrun  <= 1'b0;
            tx_done  <= 1'b1;
        end else begin
            if (rx_store)
                rx_avail <= 1'b1;
            else if (rx_release && !rx_more)
                rx_avail <= 1'b0;

            if (ovr_evt)
                overrun <= 1'b1;
            else if (ovr_clr)
                overrun <= 1'b0;

            if (tx_req)
                tx_done <= 1'b0;
            else if (tx_all_ok)
                tx_done <= 1'b1;
        end
    end
endmodule

// File: rtl/can_stat_reg.sv
module can_stat_reg
    import can_stat_pkg::*;
#(
    parameter int NUM_TXBUF = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_store_i,
    input  logic                 rx_release_i,
    input  logic                 rx_more_i,
    input  logic                 ovr_evt_i,
    input  logic                 ovr_clr_i,
    input  logic [NUM_TXBUF-1:0] tx_pend_i,
    input  logic                 tx_req_i,
    input  logic                 tx_all_ok_i,
    input  logic                 rx_active_i,
    input  logic                 tx_active_i,
    input  logic                 rxerr_inc_i,
    input  logic                 rxerr_dec_i,
    input  logic                 txerr_inc_i,
    input  logic                 txerr_dec_i,
    input  logic                 reset_mode_i,
    input  logic [7:0]           warn_lim_i,
    input  logic                 wr_en_i,
    input  logic [3:0]           wr_be_i,
    input  logic [31:0]          wr_data_i,
    output logic [31:0]          status_o
);
    logic                 wr_ok;
    logic [NUM_CNT-1:0]   c_inc, c_dec, c_load;
    logic [CNT_W-1:0]     c_val [NUM_CNT];
    logic [CNT_W-1:0]     c_q   [NUM_CNT];
    logic                 rx_avail, overrun, tx_done;
    status_t              st;

    assign wr_ok = wr_en_i & reset_mode_i;

    assign c_inc = {txerr_inc_i, rxerr_inc_i};
    assign c_dec = {txerr_dec_i, rxerr_dec_i};

    genvar g;
    generate
        for (g = 0; g < NUM_CNT; g++) begin : g_cnt
            // byte lane 2 feeds counter 0, lane 3 feeds counter 1
            assign c_load[g] = wr_ok & wr_be_i[2+g];
            assign c_val[g]  = wr_data_i[16 + 8*g +: CNT_W];
            can_stat_errcnt u_cnt (
                .clk      (clk),
                .rst      (rst),
                .inc      (c_inc[g]),
                .dec      (c_dec[g]),
                .load     (c_load[g]),
                .load_val (c_val[g]),
                .cnt      (c_q[g])
            );
        end
    endgenerate

    can_stat_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .rx_store   (rx_store_i),
        .rx_release (rx_release_i),
        .rx_more    (rx_more_i),
        .ovr_evt    (ovr_evt_i),
        .ovr_clr    (ovr_clr_i),
        .tx_req     (tx_req_i),
        .tx_all_ok  (tx_all_ok_i),
        .rx_avail   (rx_avail),
        .overrun    (overrun),
        .tx_done    (tx_done)
    );

    always_comb begin
        st          = '0;
        st.rx_avail = rx_avail;
        st.overrun  = overrun;
        st.tx_free  = ~|tx_pend_i;
        st.tx_done  = tx_done;
        st.rx_busy  = rx_active_i;
        st.tx_busy  = tx_active_i;
        st.warn     = (c_q[IDX_RX] >= warn_lim_i) || (c_q[IDX_TX] >= warn_lim_i);
        st.busoff   = (c_q[IDX_TX] == CNT_MAX);
        st.rxerr    = c_q[IDX_RX];
        st.txerr    = c_q[IDX_TX];
    end

    assign status_o = st;

endmodule

// File: rtl/can_stat_chk.sv
module can_stat_chk (
    input logic        clk,
    input logic        rst,
    input logic        ovr_clr_i,
    input logic        rx_store_i,
    input logic        rx_release_i,
    input logic        rx_more_i,
    input logic        txerr_inc_i,
    input logic        txerr_dec_i,
    input logic        rxerr_inc_i,
    input logic        rxerr_dec_i,
    input logic        reset_mode_i,
    input logic        wr_en_i,
    input logic [3:0]  wr_be_i,
    input logic [31:0] wr_data_i,
    input logic [31:0] status_o
);
    logic tx_wr;
    assign tx_wr = wr_en_i & reset_mode_i & wr_be_i[3];

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status_o[1] && !ovr_clr_i) |=> status_o[1]);                  // R3

    AST_RBS_KEEP: assert property (@(posedge clk) disable iff (rst)
        (status_o[0] && rx_more_i) |=> status_o[0]);                   // R2

    AST_TX_SAT: assert property (@(posedge clk) disable iff (rst)
        (status_o[31:24] == 8'hFF && !txerr_dec_i && !tx_wr)
        |=> status_o[31:24] == 8'hFF);                                 // R7

    AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (status_o[31:24] == 8'hFE && txerr_inc_i && !txerr_dec_i && !tx_wr)
        |=> status_o[7]);                                              // R9

    AST_SW_WINS: assert property (@(posedge clk) disable iff (rst)
        tx_wr |=> status_o[31:24] == $past(wr_data_i[31:24]));         // R10

    AST_RO_OUTSIDE_RESET: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !reset_mode_i && !txerr_inc_i && !txerr_dec_i
         && !rxerr_inc_i && !rxerr_dec_i)
        |=> $stable(status_o[31:16]));                                 // R11
endmodule

bind can_stat_reg can_stat_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ovr_clr_i    (ovr_clr_i),
    .rx_store_i   (rx_store_i),
    .rx_release_i (rx_release_i),
    .rx_more_i    (rx_more_i),
    .txerr_inc_i  (txerr_inc_i),
    .txerr_dec_i  (txerr_dec_i),
    .rxerr_inc_i  (rxerr_inc_i),
    .rxerr_dec_i  (rxerr_dec_i),
    .reset_mode_i (reset_mode_i),
    .wr_en_i      (wr_en_i),
    .wr_be_i      (wr_be_i),
    .wr_data_i    (wr_data_i),
    .status_o     (status_o)
);

// File: tb/can_stat_reg_tb_top.sv
module can_stat_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        rx_store_i, rx_release_i, rx_more_i, ovr_evt_i, ovr_clr_i;
    logic [2:0]  tx_pend_i;
    logic        tx_req_i, tx_all_ok_i, rx_active_i, tx_active_i;
    logic        rxerr_inc_i, rxerr_dec_i, txerr_inc_i, txerr_dec_i;
    logic        reset_mode_i;
    logic [7:0]  warn_lim_i;
    logic        wr_en_i;
    logic [3:0]  wr_be_i;
    logic [31:0] wr_data_i;
    logic [31:0] status_o;

    int n_run = 0;
    int n_fail = 0;
    logic       m_rbs, m_dos, m_tcs;
    logic [7:0] m_rx, m_tx;

    always #5 clk = ~clk;

    can_stat_reg #(.NUM_TXBUF(3)) dut_i (.*);

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: run did not end (actual hung, expected done)");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    function automatic logic [7:0] m_step(input logic [7:0] c, input logic up, input logic dn);
        if (up && !dn && c != 8'hFF) return c + 8'd1;
        if (dn && !up && c != 8'h00) return c - 8'd1;
        return c;
    endfunction

    function automatic logic [31:0] m_status();
        logic [31:0] s;
        s = '0;
        s[0] = m_rbs;
        s[1] = m_dos;
        s[2] = (tx_pend_i == 3'b000);
        s[3] = m_tcs;
        s[4] = rx_active_i;
        s[5] = tx_active_i;
        s[6] = (m_rx >= warn_lim_i) || (m_tx >= warn_lim_i);
        s[7] = (m_tx == 8'hFF);
        s[23:16] = m_rx;
        s[31:24] = m_tx;
        return s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        logic [31:0] e;
        e = m_status();
        chk("R2 rx_avail",  {31'd0, status_o[0]}, {31'd0, e[0]});
        chk("R3 overrun",   {31'd0, status_o[1]}, {31'd0, e[1]});
        chk("R4 tx_free",   {31'd0, status_o[2]}, {31'd0, e[2]});
        chk("R5 tx_done",   {31'd0, status_o[3]}, {31'd0, e[3]});
        chk("R6 activity",  {30'd0, status_o[5:4]}, {30'd0, e[5:4]});
        chk("R8 warn",      {31'd0, status_o[6]}, {31'd0, e[6]});
        chk("R9 busoff",    {31'd0, status_o[7]}, {31'd0, e[7]});
        chk("R12 zero",     {24'd0, status_o[15:8]}, 32'd0);
        chk("R7 counters",  {16'd0, status_o[31:16]}, {16'd0, e[31:16]});
    endtask

    task automatic idle();
        rx_store_i = 0; rx_release_i = 0; rx_more_i = 0; ovr_evt_i = 0; ovr_clr_i = 0;
        tx_req_i = 0; tx_all_ok_i = 0;
        rxerr_inc_i = 0; rxerr_dec_i = 0; txerr_inc_i = 0; txerr_dec_i = 0;
        wr_en_i = 0; wr_be_i = 4'h0; wr_data_i = '0;
    endtask

    // advance one cycle: update model at the edge, compare at the falling edge
    task automatic tick();
        @(posedge clk);
        if (rst) begin
            m_rbs = 0; m_dos = 0; m_tcs = 1; m_rx = 0; m_tx = 0;
        end else begin
            if (rx_store_i) m_rbs = 1;
            else if (rx_release_i && !rx_more_i) m_rbs = 0;
            if (ovr_evt_i) m_dos = 1;
            else if (ovr_clr_i) m_dos = 0;
            if (tx_req_i) m_tcs = 0;
            else if (tx_all_ok_i) m_tcs = 1;
            if (wr_en_i && reset_mode_i && wr_be_i[2]) m_rx = wr_data_i[23:16];
            else m_rx = m_step(m_rx, rxerr_inc_i, rxerr_dec_i);
            if (wr_en_i && reset_mode_i && wr_be_i[3]) m_tx = wr_data_i[31:24];
            else m_tx = m_step(m_tx, txerr_inc_i, txerr_dec_i);
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic sw_write(input logic rm, input logic [3:0] be, input logic [31:0] d);
        reset_mode_i = rm; wr_en_i = 1; wr_be_i = be; wr_data_i = d;
        tick();
        idle();
    endtask

    initial begin
        logic [31:0] r;
        idle();
        tx_pend_i = 3'b000; rx_active_i = 0; tx_active_i = 0;
        reset_mode_i = 0; warn_lim_i = 8'd96;
        rst = 1;
        tick(); tick();
        rst = 0;
        chk("R1 reset value", status_o, 32'h0000_000C);

        // R10: load tx counter to 254, then increment into bus-off
        sw_write(1'b1, 4'b1000, 32'hFE00_0000);
        chk("R10 tx load", {24'd0, status_o[31:24]}, 32'h0000_00FE);
        reset_mode_i = 0;
        txerr_inc_i = 1; tick();
        chk("R9 enter busoff", {31'd0, status_o[7]}, 32'd1);
        tick();
        chk("R7 tx saturate high", {24'd0, status_o[31:24]}, 32'h0000_00FF);
        idle();
        // R11: write outside reset mode ignored
        sw_write(1'b0, 4'b1111, 32'h1234_5678);
        chk("R11 ignored write", {16'd0, status_o[31:16]}, 32'h0000_FF00);
        // R10: software write wins over strobe
        reset_mode_i = 1; rxerr_inc_i = 1; txerr_dec_i = 1;
        sw_write(1'b1, 4'b1100, 32'h0005_0000);
        chk("R10 write wins", {16'd0, status_o[31:16]}, 32'h0000_0005);
        reset_mode_i = 0;
        // R7: decrement below zero saturates
        txerr_dec_i = 1; tick();
        chk("R7 tx saturate low", {24'd0, status_o[31:24]}, 32'd0);
        idle();
        // R8: warning limit exactly equal
        warn_lim_i = 8'd5; tick();
        chk("R8 warn at equal", {31'd0, status_o[6]}, 32'd1);
        // R2/R3/R5 collisions
        rx_store_i = 1; rx_release_i = 1; ovr_evt_i = 1; ovr_clr_i = 1;
        tx_req_i = 1; tx_all_ok_i = 1; tick();
        chk("R2 store beats release", {31'd0, status_o[0]}, 32'd1);
        chk("R3 set beats clear", {31'd0, status_o[1]}, 32'd1);
        chk("R5 request beats done", {31'd0, status_o[3]}, 32'd0);
        idle();
        rx_release_i = 1; rx_more_i = 1; tick();
        chk("R2 release with more", {31'd0, status_o[0]}, 32'd1);
        idle();

        // constrained random phase
        for (int i = 0; i < 3000; i++) begin
            r = $urandom;
            rx_store_i   = (r[2:0] == 0);
            rx_release_i = (r[4:3] == 0);
            rx_more_i    = r[5];
            ovr_evt_i    = (r[8:6] == 0);
            ovr_clr_i    = (r[10:9] == 0);
            tx_req_i     = (r[12:11] == 0);
            tx_all_ok_i  = (r[14:13] == 0);
            tx_pend_i    = r[15] ? 3'b000 : r[18:16];
            rx_active_i  = r[19];
            tx_active_i  = r[20];
            rxerr_inc_i  = r[21] | r[22];
            rxerr_dec_i  = r[23];
            txerr_inc_i  = r[24] | r[25];
            txerr_dec_i  = r[26];
            reset_mode_i = (r[29:27] == 0);
            wr_en_i      = (r[31:30] == 0);
            r = $urandom;
            wr_be_i      = r[3:0];
            wr_data_i    = {r[31:24], r[23:16], 16'h0000};
            if (r[11:4] == 0) warn_lim_i = r[19:12];
            tick();
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule